// File: doc/BRIEF.md
# Interrupt Set-Pending Register Bank

This block holds the pending state of every interrupt line in an interrupt distributor, and it gives software a write-one-to-set view of that state over a simple 32-bit register bus. Software marks interrupts as pending by writing ones and reads back which interrupts are pending. At the same time, hardware sources set and clear individual bits through per-interrupt strobes. The pending vectors drive the rest of the distributor directly.

The register space is one 32-bit word per group of 32 interrupt IDs. Word 0 holds the private IDs 0-31, and each processor has its own copy of it. The requesting processor's ID picks the copy. The words above word 0 hold the shared IDs, which start at 32. Each bit is filtered separately on a software access. A bit is skipped when its interrupt is not implemented, when it belongs to a software-generated interrupt, when it is configured secure and the access is non-secure, or when lockdown protects it. Read data arrives one cycle after the read strobe.

Top module: `setpend_bank`

## Requirements
- R1: A bus write with wrEn=1 to word address 0x80+k sets every pending bit whose wrData bit is 1 and that is writable. The pending output changes at the next clock edge. Data bits of 0 change nothing.
- R2: A read with rdEn=1 returns the addressed word on rdData in the next cycle. rdData shows the state from before any write made in the same cycle. In any cycle that follows a cycle without rdEn, rdData is 0.
- R3: Interrupt ID N sits in word address 0x80 + N/32, which is byte offset 0x200 + 4*(N/32), at bit N%32. There are (NUM_SPI+31)/32 + 1 words. Shared ID N appears on pendShared[N-32].
- R4: IDs at or above 32+NUM_SPI are not implemented. Their bits read 0 and ignore writes.
- R5: Word addresses outside 0x80 to 0x80+words-1 read 0 and ignore writes.
- R6: With SEC_EN=1, an access with nonSecure=1 to a bit whose irqSecure bit is 1 reads 0 and leaves the bit unchanged. Secure accesses (nonSecure=0) see and set such bits.
- R7: Software writes do not change the bits of IDs 0-15. Hardware set still raises them.
- R8: Word 0 is banked per processor, and cpuId selects the copy. When cpuId >= NUM_CPUS, a word-0 access reads 0 and writes nothing.
- R9: While lockdown=1, writes from any access do not change the bits of secure IDs 32 to 32+NUM_LOCK-1.
- R10: hwSet raises a bit and hwClr drops it at the next edge. When a set from hardware or from software meets hwClr on the same bit in the same cycle, the set wins.
- R11: Reset (rstN=0) clears every pending bit and rdData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWordAddr | input | 10 | Word address of the access (byte offset / 4) |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 32 | Write data, ones set pending bits |
| nonSecure | input | 1 | Access is non-secure |
| cpuId | input | 3 | Requesting processor, selects the word-0 copy |
| rdData | output | 32 | Read data, one cycle after rdEn |
| irqSecure | input | 32+NUM_SPI | Per-ID secure configuration |
| lockdown | input | 1 | Protects secure lockable shared IDs from writes |
| hwSetPriv | input | 32*NUM_CPUS | Hardware set, private IDs, per processor |
| hwClrPriv | input | 32*NUM_CPUS | Hardware clear, private IDs, per processor |
| hwSetShared | input | NUM_SPI | Hardware set, shared IDs |
| hwClrShared | input | NUM_SPI | Hardware clear, shared IDs |
| pendPriv | output | 32*NUM_CPUS | Pending state, private IDs, per processor |
| pendShared | output | NUM_SPI | Pending state, shared IDs |

## Verification
A wrong pending bit shows on pendPriv or pendShared one edge after the access or strobe that caused it. That is one edge before it could show on rdData through a read. A mask fault shows in two ways. If a filter is missing, a bit rises after a write that should have been dropped. If a filter is too strict, a read returns a word that disagrees with the pending outputs in the cycle after rdEn. Comparing both paths against a behavioural model on every clock catches such a fault within one or two cycles.

// File: rtl/setpend_pkg.sv
package setpend_pkg;

  localparam logic [9:0] BASE_WORD = 10'h080;

  typedef struct packed {
    logic       wrHit;
    logic       rdHit;
    logic [4:0] word;
    logic [2:0] cpu;
    logic       nonSec;
  } spStrobe_t;

endpackage

// File: rtl/setpend_ctrl.sv
module setpend_ctrl
  import setpend_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int NUM_REGS = 3
) (
  input  logic [9:0]  regWordAddr,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        nonSecure,
  input  logic [2:0]  cpuId,
  output spStrobe_t   stb
);

  localparam logic [9:0] LAST_WORD = 10'(BASE_WORD + 10'(NUM_REGS));

  logic       inWindow;
  logic [9:0] relWord;
  logic       bankOk;

  assign inWindow = (regWordAddr >= BASE_WORD) && (regWordAddr < LAST_WORD);
  assign relWord  = regWordAddr - BASE_WORD;
  // word 0 is banked: an unknown processor ID has no copy
  assign bankOk   = (relWord != 10'd0) || ({1'b0, cpuId} < 4'(NUM_CPUS));

  always_comb begin
    stb.wrHit  = wrEn && inWindow && bankOk;
    stb.rdHit  = rdEn && inWindow && bankOk;
    stb.word   = relWord[4:0];
    stb.cpu    = cpuId;
    stb.nonSec = nonSecure;
  end

endmodule

// File: rtl/setpend_dp.sv
module setpend_dp
  import setpend_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int NUM_SPI  = 60,
  parameter int NUM_LOCK = 8,
  parameter bit SEC_EN   = 1'b1,
  localparam int NUM_IRQ  = 32 + NUM_SPI,
  localparam int NUM_REGS = 1 + (NUM_SPI + 31) / 32,
  localparam int SPAN     = 32 * NUM_REGS
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  spStrobe_t               stb,
  input  logic [31:0]             wrData,
  input  logic                    lockdown,
  input  logic [NUM_IRQ-1:0]      irqSecure,
  input  logic [NUM_CPUS*32-1:0]  hwSetPriv,
  input  logic [NUM_CPUS*32-1:0]  hwClrPriv,
  input  logic [NUM_SPI-1:0]      hwSetShared,
  input  logic [NUM_SPI-1:0]      hwClrShared,
  output logic [NUM_CPUS*32-1:0]  pendPriv,
  output logic [NUM_SPI-1:0]      pendShared,
  output logic [31:0]             rdData
);

  function automatic logic [SPAN-1:0] rangeMask(input int lo, input int hi);
    logic [SPAN-1:0] m;
    for (int i = 0; i < SPAN; i++) m[i] = (i >= lo) && (i < hi);
    return m;
  endfunction

  localparam logic [SPAN-1:0] IMPL_MASK = rangeMask(0, NUM_IRQ);
  localparam logic [SPAN-1:0] SWWR_MASK = rangeMask(16, NUM_IRQ);
  localparam logic [SPAN-1:0] LOCK_ZONE = rangeMask(32, 32 + NUM_LOCK);

  logic [SPAN-1:0]          secFull;
  logic [SPAN-1:0]          hideVec;
  logic [SPAN-1:0]          lockVec;
  logic [SPAN-1:0]          rdMask;
  logic [SPAN-1:0]          wrMask;
  logic [SPAN-1:0]          swSetFull;
  logic [NUM_CPUS*32-1:0]   privQ;
  logic [NUM_SPI-1:0]       sharedQ;
  logic [31:0]              bankWord;
  logic [SPAN-1:0]          curFull;
  logic [31:0]              selWord;

  assign secFull = SPAN'(irqSecure);
  assign hideVec = (SEC_EN && stb.nonSec) ? secFull : '0;
  assign lockVec = lockdown ? (secFull & LOCK_ZONE) : '0;
  assign rdMask  = IMPL_MASK & ~hideVec;
  assign wrMask  = SWWR_MASK & ~hideVec & ~lockVec;

  // software set vector, only the addressed word is live
  always_comb begin
    swSetFull = '0;
    for (int w = 0; w < NUM_REGS; w++) begin
      if (stb.wrHit && (stb.word == 5'(w)))
        swSetFull[w*32 +: 32] = wrData & wrMask[w*32 +: 32];
    end
  end

  // banked private words
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
    logic [31:0] swPriv;
    assign swPriv = (stb.cpu == 3'(c)) ? swSetFull[31:0] : '0;
    always_ff @(posedge clk) begin
      if (!rstN) privQ[c*32 +: 32] <= '0;
      else privQ[c*32 +: 32] <= (privQ[c*32 +: 32] & ~hwClrPriv[c*32 +: 32])
                                | hwSetPriv[c*32 +: 32] | swPriv;
    end
  end

  // shared words
  always_ff @(posedge clk) begin
    if (!rstN) sharedQ <= '0;
    else sharedQ <= (sharedQ & ~hwClrShared) | hwSetShared
                    | swSetFull[32 +: NUM_SPI];
  end

  // read path
  always_comb begin
    bankWord = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (stb.cpu == 3'(c)) bankWord = privQ[c*32 +: 32];
    end
    curFull = {(SPAN-32)'(sharedQ), bankWord};
    selWord = '0;
    for (int w = 0; w < NUM_REGS; w++) begin
      if (stb.word == 5'(w)) selWord = curFull[w*32 +: 32] & rdMask[w*32 +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else rdData <= stb.rdHit ? selWord : '0;
  end

  assign pendPriv   = privQ;
  assign pendShared = sharedQ;

endmodule

// File: rtl/setpend_bank.sv
module setpend_bank
  import setpend_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int NUM_SPI  = 60,
  parameter int NUM_LOCK = 8,
  parameter bit SEC_EN   = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [9:0]              regWordAddr,
  input  logic                    wrEn,
  input  logic                    rdEn,
  input  logic [31:0]             wrData,
  input  logic                    nonSecure,
  input  logic [2:0]              cpuId,
  output logic [31:0]             rdData,
  input  logic [32+NUM_SPI-1:0]   irqSecure,
  input  logic                    lockdown,
  input  logic [NUM_CPUS*32-1:0]  hwSetPriv,
  input  logic [NUM_CPUS*32-1:0]  hwClrPriv,
  input  logic [NUM_SPI-1:0]      hwSetShared,
  input  logic [NUM_SPI-1:0]      hwClrShared,
  output logic [NUM_CPUS*32-1:0]  pendPriv,
  output logic [NUM_SPI-1:0]      pendShared
);

  localparam int NUM_REGS = 1 + (NUM_SPI + 31) / 32;

  spStrobe_t stb;

  setpend_ctrl #(.NUM_CPUS(NUM_CPUS), .NUM_REGS(NUM_REGS)) u_ctrl (
    .regWordAddr(regWordAddr), .wrEn(wrEn), .rdEn(rdEn),
    .nonSecure(nonSecure), .cpuId(cpuId), .stb(stb)
  );

  setpend_dp #(.NUM_CPUS(NUM_CPUS), .NUM_SPI(NUM_SPI),
               .NUM_LOCK(NUM_LOCK), .SEC_EN(SEC_EN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .lockdown(lockdown), .irqSecure(irqSecure),
    .hwSetPriv(hwSetPriv), .hwClrPriv(hwClrPriv),
    .hwSetShared(hwSetShared), .hwClrShared(hwClrShared),
    .pendPriv(pendPriv), .pendShared(pendShared), .rdData(rdData)
  );

endmodule

// File: rtl/setpend_chk.sv
module setpend_chk #(
  parameter int NUM_CPUS = 2,
  parameter int NUM_SPI  = 60
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [9:0]              regWordAddr,
  input logic                    wrEn,
  input logic                    rdEn,
  input logic [31:0]             rdData,
  input logic [NUM_CPUS*32-1:0]  hwSetPriv,
  input logic [NUM_SPI-1:0]      hwSetShared,
  input logic [NUM_SPI-1:0]      hwClrShared,
  input logic [NUM_CPUS*32-1:0]  pendPriv,
  input logic [NUM_SPI-1:0]      pendShared
);

  localparam int NUM_REGS = 1 + (NUM_SPI + 31) / 32;

  logic outWindow;
  assign outWindow = (regWordAddr < 10'h080) || (regWordAddr >= 10'(10'h080 + NUM_REGS));

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_sgi
    // R7
    sgi_sw_ro_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pendPriv[c*32 +: 16] & ~$past(pendPriv[c*32 +: 16])
        & ~$past(hwSetPriv[c*32 +: 16])) == 16'h0);
  end

  // R10
  hw_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (~pendShared & $past(hwSetShared)) == '0);

  // R10
  hw_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn) |-> ((pendShared & $past(hwClrShared & ~hwSetShared)) == '0));

  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdEn) |-> (rdData == 32'h0));

  // R5
  rd_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdEn) && $past(outWindow)) |-> (rdData == 32'h0));

endmodule

bind setpend_bank setpend_chk #(.NUM_CPUS(NUM_CPUS), .NUM_SPI(NUM_SPI)) u_chk (
  .clk(clk), .rstN(rstN), .regWordAddr(regWordAddr), .wrEn(wrEn),
  .rdEn(rdEn), .rdData(rdData), .hwSetPriv(hwSetPriv),
  .hwSetShared(hwSetShared), .hwClrShared(hwClrShared),
  .pendPriv(pendPriv), .pendShared(pendShared)
);

// File: tb/tb_setpend_bank.sv
module tb_setpend_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int NSPI = 60;
  localparam int NLOCK = 8;
  localparam int NIRQ = 32 + NSPI;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] regWordAddr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0, nonSecure = 1'b0, lockdown = 1'b0;
  logic [31:0] wrData = '0;
  logic [2:0] cpuId = '0;
  logic [31:0] rdData;
  logic [NIRQ-1:0] irqSecure;
  logic [NC*32-1:0] hwSetPriv = '0, hwClrPriv = '0, pendPriv;
  logic [NSPI-1:0] hwSetShared = '0, hwClrShared = '0, pendShared;

  int checks = 0, fails = 0;
  bit done = 0;

  setpend_bank #(.NUM_CPUS(NC), .NUM_SPI(NSPI), .NUM_LOCK(NLOCK), .SEC_EN(1'b1)) dut (
    .clk(clk), .rstN(rstN), .regWordAddr(regWordAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .nonSecure(nonSecure), .cpuId(cpuId), .rdData(rdData),
    .irqSecure(irqSecure), .lockdown(lockdown), .hwSetPriv(hwSetPriv),
    .hwClrPriv(hwClrPriv), .hwSetShared(hwSetShared), .hwClrShared(hwClrShared),
    .pendPriv(pendPriv), .pendShared(pendShared)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit [NC*32-1:0] mPriv;
  bit [NSPI-1:0]  mShared;
  bit [31:0]      mRd;

  always @(posedge clk) begin : model
    int rel;
    bit inWin, bankOk, sw;
    bit [NC*32-1:0] nPriv;
    bit [NSPI-1:0] nShared;
    if (!rstN) begin
      mPriv = '0; mShared = '0; mRd = '0;
    end else begin
      inWin = (regWordAddr >= 10'h080) && (regWordAddr < 10'h083);
      rel = int'(regWordAddr) - 'h80;
      bankOk = (rel != 0) || (cpuId < 3'(NC));
      mRd = '0;
      if (rdEn && inWin && bankOk) begin
        for (int b = 0; b < 32; b++) begin
          int id;
          bit p;
          id = rel * 32 + b;
          if (id < NIRQ && !(nonSecure && irqSecure[id])) begin
            p = (id < 32) ? mPriv[int'(cpuId)*32 + b] : mShared[id-32];
            mRd[b] = p;
          end
        end
      end
      for (int c = 0; c < NC; c++)
        for (int b = 0; b < 32; b++) begin
          sw = wrEn && inWin && rel == 0 && int'(cpuId) == c && b >= 16 && wrData[b]
               && !(nonSecure && irqSecure[b]);
          nPriv[c*32+b] = sw || hwSetPriv[c*32+b] || (mPriv[c*32+b] && !hwClrPriv[c*32+b]);
        end
      for (int k = 0; k < NSPI; k++) begin
        int id;
        id = 32 + k;
        sw = wrEn && inWin && rel == id/32 && wrData[id%32]
             && !(nonSecure && irqSecure[id]) && !(lockdown && irqSecure[id] && id < 32 + NLOCK);
        nShared[k] = sw || hwSetShared[k] || (mShared[k] && !hwClrShared[k]);
      end
      mPriv = nPriv; mShared = nShared;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(pendPriv == mPriv, "R1/R10 model pendPriv", 64'(pendPriv), 64'(mPriv));
      check(pendShared == mShared, "R1/R10 model pendShared", 64'(pendShared), 64'(mShared));
      check(rdData == mRd, "R2 model rdData", 64'(rdData), 64'(mRd));
    end
  end

  task automatic doWrite(input logic [2:0] cpu, input bit ns, input logic [9:0] wa, input logic [31:0] d);
    cpuId = cpu; nonSecure = ns; regWordAddr = wa; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic doRead(input logic [2:0] cpu, input bit ns, input logic [9:0] wa, output logic [31:0] d);
    cpuId = cpu; nonSecure = ns; regWordAddr = wa; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic clearAll();
    hwClrShared = '1; hwClrPriv = '1;
    @(negedge clk);
    hwClrShared = '0; hwClrPriv = '0;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] r, e;
    for (int i = 0; i < NIRQ; i++) irqSecure[i] = (i % 3 == 0);
    repeat (3) @(negedge clk);
    // R11 reset state
    check(pendPriv == '0 && pendShared == '0, "R11 reset pend", 64'(pendShared), 64'h0);
    check(rdData == '0, "R11 reset rdData", 64'(rdData), 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 set via write, read back
    doWrite(3'd0, 1'b0, 10'h080, 32'h000F0000);
    doRead(3'd0, 1'b0, 10'h080, r);
    check(r == 32'h000F0000, "R1 write-one-to-set", 64'(r), 64'h000F0000);
    @(negedge clk);
    check(rdData == 32'h0, "R2 idle rdData zero", 64'(rdData), 64'h0);
    // R6 secure ID 18 hidden from non-secure read
    doRead(3'd0, 1'b1, 10'h080, r);
    check(r == 32'h000B0000, "R6 ns read hides secure", 64'(r), 64'h000B0000);
    // R8 other bank untouched
    doRead(3'd1, 1'b0, 10'h080, r);
    check(r == 32'h0, "R8 bank1 separate", 64'(r), 64'h0);

    // R7 software cannot set SGIs, hardware can
    doWrite(3'd0, 1'b0, 10'h080, 32'h0000FFFF);
    doRead(3'd0, 1'b0, 10'h080, r);
    check(r == 32'h000F0000, "R7 sgi write ignored", 64'(r), 64'h000F0000);
    hwSetPriv[3] = 1'b1; @(negedge clk); hwSetPriv[3] = 1'b0;
    doRead(3'd0, 1'b0, 10'h080, r);
    check(r == 32'h000F0008, "R7 sgi hw set", 64'(r), 64'h000F0008);

    // R8 invalid cpu ignored, cpu1 own copy
    doWrite(3'd2, 1'b0, 10'h080, 32'h00100000);
    doRead(3'd2, 1'b0, 10'h080, r);
    check(r == 32'h0, "R8 invalid cpu reads zero", 64'(r), 64'h0);
    doWrite(3'd1, 1'b0, 10'h080, 32'h00200000);
    doRead(3'd1, 1'b0, 10'h080, r);
    check(r == 32'h00200000, "R8 bank1 write", 64'(r), 64'h00200000);
    doRead(3'd0, 1'b0, 10'h080, r);
    check(r == 32'h000F0008, "R8 bank0 unchanged", 64'(r), 64'h000F0008);

    // R3 mapping: ID 77 -> word 0x82 bit 13, pendShared[45]
    hwSetShared[45] = 1'b1; @(negedge clk); hwSetShared[45] = 1'b0;
    check(pendShared[45] == 1'b1, "R3 pendShared index", 64'(pendShared), 64'h1 << 45);
    doRead(3'd0, 1'b0, 10'h082, r);
    check(r == 32'h00002000, "R3 word/bit mapping", 64'(r), 64'h00002000);
    clearAll();

    // R6 non-secure write sets only non-secure bits
    e = '0;
    for (int b = 0; b < 32; b++) e[b] = ((32 + b) % 3 != 0);
    doWrite(3'd0, 1'b1, 10'h081, 32'hFFFFFFFF);
    doRead(3'd0, 1'b0, 10'h081, r);
    check(r == e, "R6 ns write filtered", 64'(r), 64'(e));
    doWrite(3'd0, 1'b0, 10'h081, 32'hFFFFFFFF);
    doRead(3'd0, 1'b1, 10'h081, r);
    check(r == e, "R6 ns read filtered", 64'(r), 64'(e));
    doRead(3'd0, 1'b0, 10'h081, r);
    check(r == 32'hFFFFFFFF, "R6 secure read full", 64'(r), 64'hFFFFFFFF);
    clearAll();

    // R10 software set beats hardware clear
    hwClrShared[5] = 1'b1;
    doWrite(3'd0, 1'b0, 10'h081, 32'h00000020);
    hwClrShared[5] = 1'b0;
    doRead(3'd0, 1'b0, 10'h081, r);
    check(r == 32'h00000020, "R10 sw set wins", 64'(r), 64'h20);
    hwSetShared[6] = 1'b1; hwClrShared[6] = 1'b1; @(negedge clk);
    hwSetShared[6] = 1'b0; hwClrShared[6] = 1'b0;
    check(pendShared[6] == 1'b1, "R10 hw set wins", 64'(pendShared), 64'h40);
    hwClrShared[5] = 1'b1; @(negedge clk); hwClrShared[5] = 1'b0;
    check(pendShared[5] == 1'b0, "R10 hw clear", 64'(pendShared), 64'h40);
    clearAll();

    // R9 lockdown protects secure IDs 33,36,39
    lockdown = 1'b1;
    doWrite(3'd0, 1'b0, 10'h081, 32'hFFFFFFFF);
    lockdown = 1'b0;
    doRead(3'd0, 1'b0, 10'h081, r);
    check(r == 32'hFFFFFF6D, "R9 lockdown", 64'(r), 64'hFFFFFF6D);
    clearAll();

    // R4 unimplemented IDs 92..95
    doWrite(3'd0, 1'b0, 10'h082, 32'hFFFFFFFF);
    doRead(3'd0, 1'b0, 10'h082, r);
    check(r == 32'h0FFFFFFF, "R4 unimplemented zero", 64'(r), 64'h0FFFFFFF);

    // R5 outside window
    doWrite(3'd0, 1'b0, 10'h083, 32'hFFFFFFFF);
    doWrite(3'd0, 1'b0, 10'h07F, 32'hFFFFFFFF);
    check(pendShared[31:0] == 32'h0, "R5 write outside ignored", 64'(pendShared), 64'hFFFFFFF << 32);
    doRead(3'd0, 1'b0, 10'h083, r);
    check(r == 32'h0, "R5 read outside zero", 64'(r), 64'h0);
    doRead(3'd0, 1'b0, 10'h07F, r);
    check(r == 32'h0, "R5 read below zero", 64'(r), 64'h0);

    // R11 reset mid-run
    rstN = 1'b0; @(negedge clk);
    check(pendShared == '0 && pendPriv == '0, "R11 reset clears", 64'(pendShared), 64'h0);
    rstN = 1'b1; @(negedge clk);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule